// File: doc/BRIEF.md
# Host-to-Slave-Array Access Bridge

This block sits between one bus master and a row of up to five slave processors that share a single slave-side port. The master raises a chip select with an address. The bridge takes a slave number from the top bits of that address and drives the matching per-slave select line. A second master-side select, the group select, sends one write to every slave at the same time.

In bridged mode, writes are posted into a small queue that holds address, data and byte enables. The master therefore moves on at once, and the queue drains towards the slaves at one entry per cycle. A read waits until the queue is empty, so a read never overtakes an earlier write. Bursts always carry 256 bits. The bridge works out the beat count from the data width and steps the address beat by beat. A slave-side wait line holds the current slave access in place.

A second mode, the straight-through mode, is meant for a slave port without a clock. In this mode the bridge skips the queue and the burst logic and maps master strobes onto the slave port combinationally.

Top module: `host_slave_bridge`

## Requirements
- R1: Out of reset the bridge shows `m_ready` high, no slave select, and neither `m_rvalid` nor `m_err`.
- R2: With `m_cs` high and `m_bcs` low, address bits [AW-1:AW-4] hold a slave number k. For k below NSLV, only `s_sel[k]` is raised, and `s_addr` carries address bits [AW-5:0].
- R3: A slave number of NSLV or above selects no slave. `m_err` pulses in the cycle after the beat is accepted.
- R4: A write with `m_bcs` high raises every `s_sel` bit in one slave cycle, whatever `m_cs` holds. `m_bcs` takes priority over `m_cs`.
- R5: A read with `m_bcs` high makes no slave access and pulses `m_err` one cycle after acceptance.
- R6: In bridged mode, a write accepted at a clock edge is presented on the slave port from the next cycle on. Queued writes reach the slaves in acceptance order, one per cycle.
- R7: The write queue holds WB_DEPTH entries. When it is full, `m_ready` is low for writes.
- R8: A read is not accepted (`m_ready` low) while the queue holds any entry or `s_wait` is high.
- R9: In bridged mode, a good read drives the slave port in its acceptance cycle. `m_rvalid` and the selected slave's word appear on `m_rdata` one cycle later.
- R10: `m_burst` on the first beat starts a burst of 256/DW beats. Beat k uses the first beat's address plus k·DW/8 bytes. Slave number, direction and group select are taken from the first beat.
- R11: Byte enables `m_be` reach `s_be` unchanged, on every beat, for each selected slave.
- R12: With `pass_mode` high, the slave port follows the master inputs in the same cycle, with no queueing. `m_ready` stays high, and read data and errors return combinationally.
- R13: In bridged mode, while `s_wait` is high the slave write on the port, with its select and address, is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pass_mode | input | 1 | 1: straight-through mapping; 0: bridged mode |
| m_cs | input | 1 | Master chip select for one slave |
| m_bcs | input | 1 | Master group select (write to all slaves) |
| m_burst | input | 1 | First beat starts a 256-bit burst |
| m_write | input | 1 | 1 write, 0 read |
| m_addr | input | AW | Byte address; top 4 bits are the slave number |
| m_wdata | input | DW | Write data |
| m_be | input | DW/8 | Byte enables |
| m_ready | output | 1 | Current beat is accepted at this edge |
| m_rvalid | output | 1 | Read data valid |
| m_rdata | output | DW | Read data |
| m_err | output | 1 | Error response for an accepted beat |
| s_sel | output | NSLV | Per-slave select |
| s_we | output | 1 | Slave write strobe |
| s_addr | output | AW-4 | Slave-local address |
| s_wdata | output | DW | Slave write data |
| s_be | output | DW/8 | Slave byte enables |
| s_rdata | input | NSLV·DW | Read words of all slaves, slave i at [i·DW +: DW] |
| s_wait | input | 1 | Slave holds the current access |

## Verification
The bench builds the bridge with a 32-bit data width, which gives eight-beat bursts, so the address stepping of R10 covers the full count range. It uses a queue depth of three, so a handful of held cycles on `s_wait` is enough to fill the queue and hit the full-queue stall and the read-behind-write stall. A 16-bit address gives a 12-bit slave-local field. With five slaves, numbers 5 to 15 lie in the error range.

// File: rtl/hsb_pkg.sv
// Shared constants, helpers and types for the host-to-slave-array bridge.
// Assumes the burst size is fixed at 256 bits for every data width.
package hsb_pkg;

    localparam int BURST_BITS = 256;

    // Number of beats that make up one burst at a given data width.
    function automatic int burst_beats(input int dw);
        return BURST_BITS / dw;
    endfunction

    // Which source currently owns the shared slave port.
    typedef enum logic [1:0] {
        PORT_IDLE  = 2'd0,
        PORT_DRAIN = 2'd1,
        PORT_READ  = 2'd2,
        PORT_PASS  = 2'd3
    } port_owner_e;

endpackage

// File: rtl/hsb_decode.sv
// Slave-number decoder: turns a slave number plus the group flag into
// per-slave selects and an error flag.
// Assumes group reads are illegal and numbers >= NSLV have no slave.
module hsb_decode #(
    parameter int NSLV = 5,
    parameter int IDW  = 4
) (
    input  logic [IDW-1:0]  id,
    input  logic            bcast,
    input  logic            write,
    output logic [NSLV-1:0] sel,
    output logic            bad
);

    localparam logic [IDW:0] LIMIT = (IDW+1)'(NSLV);

    // Error when a group read is attempted or no slave owns the number.
    always_comb begin
        if (bcast) bad = !write;
        else       bad = ({1'b0, id} >= LIMIT);
    end

    // One select bit per slave.
    for (genvar i = 0; i < NSLV; i++) begin : g_sel
        assign sel[i] = !bad && (bcast || (id == IDW'(i)));
    end

endmodule

// File: rtl/hsb_burst.sv
// Burst sequencer: captures the first beat of a burst and supplies the
// effective slave number, direction, group flag and stepped address for
// every later beat.
// Assumes the master presents each beat as a separate accepted handshake.
module hsb_burst #(
    parameter int SAW = 20,
    parameter int IDW = 4,
    parameter int DW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           accept,
    input  logic           burst,
    input  logic           in_write,
    input  logic           in_bcast,
    input  logic [IDW-1:0] in_id,
    input  logic [SAW-1:0] in_addr,
    output logic           eff_write,
    output logic           eff_bcast,
    output logic [IDW-1:0] eff_id,
    output logic [SAW-1:0] eff_addr
);

    import hsb_pkg::*;

    localparam int BEATS = burst_beats(DW);
    localparam int OFF   = $clog2(DW/8);

    if (BEATS > 1) begin : g_seq
        localparam int BCW = $clog2(BEATS);

        logic           act_q;
        logic [BCW-1:0] cnt_q;
        logic           wr_q, bc_q;
        logic [IDW-1:0] id_q;
        logic [SAW-1:0] base_q;

        // Track burst position and hold the first beat's attributes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_q  <= 1'b0;
                cnt_q  <= '0;
                wr_q   <= 1'b0;
                bc_q   <= 1'b0;
                id_q   <= '0;
                base_q <= '0;
            end else if (accept) begin
                if (!act_q) begin
                    if (burst) begin
                        act_q  <= 1'b1;
                        cnt_q  <= BCW'(1);
                        wr_q   <= in_write;
                        bc_q   <= in_bcast;
                        id_q   <= in_id;
                        base_q <= in_addr;
                    end
                end else begin
                    if (cnt_q == BCW'(BEATS-1)) act_q <= 1'b0;
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end

        // Select live inputs on a first beat, captured values afterwards.
        always_comb begin
            if (act_q) begin
                eff_write = wr_q;
                eff_bcast = bc_q;
                eff_id    = id_q;
                eff_addr  = base_q + (SAW'(cnt_q) << OFF);
            end else begin
                eff_write = in_write;
                eff_bcast = in_bcast;
                eff_id    = in_id;
                eff_addr  = in_addr;
            end
        end
    end else begin : g_single
        // A single beat already carries 256 bits: nothing to sequence.
        assign eff_write = in_write;
        assign eff_bcast = in_bcast;
        assign eff_id    = in_id;
        assign eff_addr  = in_addr;
    end

endmodule

// File: rtl/hsb_wbuf.sv
// Posting queue for writes: stores packed entries (selects, address,
// data, byte enables) in arrival order.
// Assumes the caller never pushes when full nor pops when empty.
module hsb_wbuf #(
    parameter int EW    = 64,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [EW-1:0] din,
    input  logic          pop,
    output logic [EW-1:0] dout,
    output logic          empty,
    output logic          full
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [EW-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    // Entry storage, written at the tail.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= step(wp);
            if (pop)  rp <= step(rp);
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign dout  = mem[rp];
    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));

endmodule

// File: rtl/host_slave_bridge.sv
// Host-to-slave-array bridge top. Decodes a slave number from the top
// address bits, posts writes into a queue, serialises reads behind the
// queue, sequences 256-bit bursts, and offers a straight-through mode.
// Assumes a single clock and that pass_mode changes only while idle.
module host_slave_bridge #(
    parameter int NSLV     = 5,
    parameter int IDW      = 4,
    parameter int AW       = 24,
    parameter int DW       = 32,
    parameter int WB_DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pass_mode,
    input  logic                 m_cs,
    input  logic                 m_bcs,
    input  logic                 m_burst,
    input  logic                 m_write,
    input  logic [AW-1:0]        m_addr,
    input  logic [DW-1:0]        m_wdata,
    input  logic [DW/8-1:0]      m_be,
    output logic                 m_ready,
    output logic                 m_rvalid,
    output logic [DW-1:0]        m_rdata,
    output logic                 m_err,
    output logic [NSLV-1:0]      s_sel,
    output logic                 s_we,
    output logic [AW-IDW-1:0]    s_addr,
    output logic [DW-1:0]        s_wdata,
    output logic [DW/8-1:0]      s_be,
    input  logic [NSLV*DW-1:0]   s_rdata,
    input  logic                 s_wait
);

    import hsb_pkg::*;

    localparam int BEW = DW / 8;
    localparam int SAW = AW - IDW;
    localparam int EW  = NSLV + SAW + DW + BEW;

    logic            req, acc, push, pop, rd_go, rdy;
    logic            eff_write, eff_bcast, bad;
    logic [IDW-1:0]  eff_id;
    logic [SAW-1:0]  eff_addr;
    logic [NSLV-1:0] sel_dec;
    logic            q_empty, q_full;
    logic [EW-1:0]   head;
    logic [NSLV-1:0] h_sel;
    logic [SAW-1:0]  h_addr;
    logic [DW-1:0]   h_data;
    logic [BEW-1:0]  h_be;
    logic [DW-1:0]   rd_word;
    logic            rvalid_q, err_q;
    logic [DW-1:0]   rdata_q;
    port_owner_e     owner;

    assign req = m_cs | m_bcs;

    hsb_burst #(.SAW(SAW), .IDW(IDW), .DW(DW)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (acc),
        .burst     (m_burst),
        .in_write  (m_write),
        .in_bcast  (m_bcs),
        .in_id     (m_addr[AW-1 -: IDW]),
        .in_addr   (m_addr[SAW-1:0]),
        .eff_write (eff_write),
        .eff_bcast (eff_bcast),
        .eff_id    (eff_id),
        .eff_addr  (eff_addr)
    );

    hsb_decode #(.NSLV(NSLV), .IDW(IDW)) u_dec (
        .id    (eff_id),
        .bcast (eff_bcast),
        .write (eff_write),
        .sel   (sel_dec),
        .bad   (bad)
    );

    hsb_wbuf #(.EW(EW), .DEPTH(WB_DEPTH)) u_wbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   ({sel_dec, eff_addr, m_wdata, m_be}),
        .pop   (pop),
        .dout  (head),
        .empty (q_empty),
        .full  (q_full)
    );

    assign {h_sel, h_addr, h_data, h_be} = head;

    // Acceptance rules: writes need queue room, reads need an idle queue and slave.
    assign rdy     = eff_write ? !q_full : (q_empty && !s_wait);
    assign acc     = req && rdy && !pass_mode;
    assign push    = acc && eff_write && !bad;
    assign rd_go   = acc && !eff_write && !bad;
    assign pop     = !q_empty && !s_wait && !pass_mode;
    assign m_ready = pass_mode || rdy;

    // Decide which source owns the slave port this cycle.
    always_comb begin
        if (pass_mode)     owner = PORT_PASS;
        else if (!q_empty) owner = PORT_DRAIN;
        else if (rd_go)    owner = PORT_READ;
        else               owner = PORT_IDLE;
    end

    // Drive the shared slave port from the owning source.
    always_comb begin
        case (owner)
            PORT_PASS: begin
                s_sel   = req ? sel_dec : '0;
                s_we    = m_write;
                s_addr  = m_addr[SAW-1:0];
                s_wdata = m_wdata;
                s_be    = m_be;
            end
            PORT_DRAIN: begin
                s_sel   = h_sel;
                s_we    = 1'b1;
                s_addr  = h_addr;
                s_wdata = h_data;
                s_be    = h_be;
            end
            PORT_READ: begin
                s_sel   = sel_dec;
                s_we    = 1'b0;
                s_addr  = eff_addr;
                s_wdata = '0;
                s_be    = m_be;
            end
            default: begin
                s_sel   = '0;
                s_we    = 1'b0;
                s_addr  = '0;
                s_wdata = '0;
                s_be    = '0;
            end
        endcase
    end

    // Pick the addressed slave's read word.
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NSLV; i++) begin
            if (sel_dec[i]) rd_word = rd_word | s_rdata[i*DW +: DW];
        end
    end

    // Register read data and error responses for bridged mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
            err_q    <= 1'b0;
        end else begin
            rvalid_q <= rd_go;
            rdata_q  <= rd_go ? rd_word : '0;
            err_q    <= acc && bad;
        end
    end

    assign m_rvalid = pass_mode ? (req && !m_write && !bad) : rvalid_q;
    assign m_rdata  = pass_mode ? rd_word : rdata_q;
    assign m_err    = pass_mode ? (req && bad) : err_q;

endmodule

// File: rtl/hsb_checks.sv
// Protocol checker for the bridge, attached to every instance by bind.
// Assumes the master keeps m_write constant across the beats of a burst.
module hsb_checks #(
    parameter int NSLV = 5,
    parameter int AW   = 24,
    parameter int IDW  = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                pass_mode,
    input logic                m_bcs,
    input logic                m_write,
    input logic                m_ready,
    input logic                m_rvalid,
    input logic                m_err,
    input logic [NSLV-1:0]     s_sel,
    input logic                s_we,
    input logic [AW-IDW-1:0]   s_addr,
    input logic                s_wait
);

    // Selects are either a single slave or the whole group.
    assert_sel_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|s_sel) |-> (($countones(s_sel) == 1) || (&s_sel)));

    // An accepted group write shows up on the slave port next cycle.
    assert_post_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass_mode && m_bcs && m_write && m_ready) |=> (pass_mode || (s_we && (|s_sel))));

    // A slave-port read is answered with read data one cycle later.
    assert_read_answer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass_mode && (|s_sel) && !s_we && !s_wait) |=> (pass_mode || m_rvalid));

    // An error beat never also returns data.
    assert_err_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pass_mode |-> !(m_err && m_rvalid));

    // A held slave write keeps its select and address.
    assert_wait_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass_mode && s_wait && s_we && (|s_sel)) |=>
        (pass_mode || ($stable(s_sel) && $stable(s_addr) && s_we)));

endmodule

bind host_slave_bridge hsb_checks #(.NSLV(NSLV), .AW(AW), .IDW(IDW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pass_mode (pass_mode),
    .m_bcs     (m_bcs),
    .m_write   (m_write),
    .m_ready   (m_ready),
    .m_rvalid  (m_rvalid),
    .m_err     (m_err),
    .s_sel     (s_sel),
    .s_we      (s_we),
    .s_addr    (s_addr),
    .s_wait    (s_wait)
);

// File: tb/sim_host_slave_bridge.sv
// Bench: behavioural reference model (queue, integers) compared every cycle.
module sim_host_slave_bridge;

    localparam int NSLV = 5, IDW = 4, AW = 16, DW = 32, WB_DEPTH = 3;
    localparam int BEW = DW/8, SAW = AW-IDW, BEATS = 256/DW, OFF = 2;

    logic clk = 1'b0, rst_n = 1'b0, pass_mode = 1'b0;
    logic m_cs = 0, m_bcs = 0, m_burst = 0, m_write = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_wdata = '0;
    logic [BEW-1:0] m_be = '0;
    logic m_ready, m_rvalid, m_err, s_we;
    logic [DW-1:0] m_rdata, s_wdata;
    logic [NSLV-1:0] s_sel;
    logic [SAW-1:0] s_addr;
    logic [BEW-1:0] s_be;
    logic [NSLV*DW-1:0] s_rdata;
    logic s_wait = 1'b0;

    always #5 clk = ~clk;

    host_slave_bridge #(.NSLV(NSLV), .IDW(IDW), .AW(AW), .DW(DW), .WB_DEPTH(WB_DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .pass_mode(pass_mode), .m_cs(m_cs), .m_bcs(m_bcs),
        .m_burst(m_burst), .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_be(m_be), .m_ready(m_ready), .m_rvalid(m_rvalid), .m_rdata(m_rdata),
        .m_err(m_err), .s_sel(s_sel), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata),
        .s_be(s_be), .s_rdata(s_rdata), .s_wait(s_wait));

    // Slave models, driven only by the bridge's slave port.
    logic [DW-1:0] smem [NSLV][64];
    always_comb
        for (int i = 0; i < NSLV; i++) s_rdata[i*DW +: DW] = smem[i][s_addr[OFF+5:OFF]];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLV; i++)
                for (int j = 0; j < 64; j++) smem[i][j] <= {8'hA0 + 8'(i), 24'(j)};
        end else if (s_we && !s_wait) begin
            for (int i = 0; i < NSLV; i++)
                if (s_sel[i])
                    for (int b = 0; b < BEW; b++)
                        if (s_be[b]) smem[i][s_addr[OFF+5:OFF]][b*8 +: 8] <= s_wdata[b*8 +: 8];
        end
    end

    // Reference model state.
    typedef struct { logic [NSLV-1:0] sel; logic [SAW-1:0] a; logic [DW-1:0] d; logic [BEW-1:0] be; } ent_t;
    ent_t q[$];
    logic [DW-1:0] rmem [NSLV][64];
    int  mact = 0, mcnt = 0;
    logic b_wr, b_bc; logic [IDW-1:0] b_id; logic [SAW-1:0] b_a;
    logic exp_rv = 0, exp_err = 0; logic [DW-1:0] exp_rd = '0;
    int errors = 0, checks = 0;
    string tag = "R1";

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic apply(input logic [NSLV-1:0] sel, input logic [SAW-1:0] a,
                         input logic [DW-1:0] d, input logic [BEW-1:0] be);
        for (int i = 0; i < NSLV; i++)
            if (sel[i])
                for (int b = 0; b < BEW; b++)
                    if (be[b]) rmem[i][a[OFF+5:OFF]][b*8 +: 8] = d[b*8 +: 8];
    endtask

    // One clock: compare outputs mid-cycle, advance the model at the edge.
    task automatic step(output bit took);
        logic req, ew, eb, bad, rdy, acc, xwe; logic [IDW-1:0] eid; logic [SAW-1:0] ea;
        logic [NSLV-1:0] dsel, xsel; logic [SAW-1:0] xa; logic [DW-1:0] xd; logic [BEW-1:0] xbe;
        logic [DW-1:0] rword;
        #1;
        req = m_cs | m_bcs;
        if (mact != 0 && !pass_mode) begin ew = b_wr; eb = b_bc; eid = b_id; ea = b_a + SAW'(mcnt*BEW); end
        else begin ew = m_write; eb = m_bcs; eid = m_addr[AW-1 -: IDW]; ea = m_addr[SAW-1:0]; end
        bad = eb ? !ew : (int'(eid) >= NSLV);
        dsel = '0;
        if (!bad) for (int i = 0; i < NSLV; i++) dsel[i] = eb || (int'(eid) == i);
        rword = (!bad && !eb) ? rmem[eid][ea[OFF+5:OFF]] : '0;
        rdy = pass_mode ? 1'b1 : (ew ? (q.size() < WB_DEPTH) : (q.size() == 0 && !s_wait));
        acc = req && rdy && !pass_mode;
        if (pass_mode) begin xsel = req ? dsel : '0; xwe = m_write; xa = ea; xd = m_wdata; xbe = m_be; end
        else if (q.size() != 0) begin xsel = q[0].sel; xwe = 1; xa = q[0].a; xd = q[0].d; xbe = q[0].be; end
        else if (acc && !ew && !bad) begin xsel = dsel; xwe = 0; xa = ea; xd = '0; xbe = m_be; end
        else begin xsel = '0; xwe = 0; xa = '0; xd = '0; xbe = '0; end
        chk(m_ready === rdy, "m_ready", 64'(m_ready), 64'(rdy));
        chk(s_sel === xsel, "s_sel", 64'(s_sel), 64'(xsel));
        chk(s_we === xwe, "s_we", 64'(s_we), 64'(xwe));
        chk(s_addr === xa, "s_addr", 64'(s_addr), 64'(xa));
        chk(s_wdata === xd, "s_wdata", 64'(s_wdata), 64'(xd));
        chk(s_be === xbe, "s_be", 64'(s_be), 64'(xbe));
        if (pass_mode) begin
            chk(m_rvalid === (req && !m_write && !bad), "m_rvalid", 64'(m_rvalid), 64'(req && !m_write && !bad));
            chk(m_err === (req && bad), "m_err", 64'(m_err), 64'(req && bad));
            if (req && !m_write && !bad) chk(m_rdata === rword, "m_rdata", 64'(m_rdata), 64'(rword));
        end else begin
            chk(m_rvalid === exp_rv, "m_rvalid", 64'(m_rvalid), 64'(exp_rv));
            chk(m_err === exp_err, "m_err", 64'(m_err), 64'(exp_err));
            if (exp_rv) chk(m_rdata === exp_rd, "m_rdata", 64'(m_rdata), 64'(exp_rd));
        end
        took = req && m_ready;
        @(posedge clk);
        if (pass_mode) begin
            if (req && m_write && !bad) apply(dsel, ea, m_wdata, m_be);
            exp_rv = 0; exp_err = 0;
        end else begin
            exp_rv = acc && !ew && !bad; exp_rd = rword; exp_err = acc && bad;
            if (q.size() != 0 && !s_wait) begin apply(q[0].sel, q[0].a, q[0].d, q[0].be); void'(q.pop_front()); end
            if (acc && ew && !bad) q.push_back('{dsel, ea, m_wdata, m_be});
            if (acc) begin
                if (mact == 0) begin
                    if (m_burst) begin mact = 1; mcnt = 1; b_wr = m_write; b_bc = m_bcs; b_id = eid; b_a = ea; end
                end else begin
                    if (mcnt == BEATS-1) mact = 0;
                    mcnt = (mcnt + 1) % BEATS;
                end
            end
        end
        @(negedge clk);
    endtask

    function automatic logic [AW-1:0] ad(input int id, input int word);
        return {IDW'(id), SAW'(word*BEW)};
    endfunction

    task automatic beat(input logic cs, input logic bc, input logic bu, input logic wr,
                        input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BEW-1:0] be);
        bit took;
        m_cs = cs; m_bcs = bc; m_burst = bu; m_write = wr; m_addr = a; m_wdata = d; m_be = be;
        do step(took); while (!took);
    endtask

    task automatic idle(input int n);
        bit took;
        m_cs = 0; m_bcs = 0; m_burst = 0; m_write = 0;
        for (int k = 0; k < n; k++) step(took);
    endtask

    initial begin
        #20000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit took;
        for (int i = 0; i < NSLV; i++)
            for (int j = 0; j < 64; j++) rmem[i][j] = {8'hA0 + 8'(i), 24'(j)};
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state seen right after reset release
        tag = "R1";
        #1;
        chk(m_ready === 1'b1 && s_sel === '0 && !m_rvalid && !m_err, "reset outputs",
            64'({m_ready, s_sel, m_rvalid, m_err}), 64'({1'b1, 5'b0, 2'b0}));
        @(negedge clk);
        idle(2);

        tag = "R2";  // per-slave decode, then read-back (R9)
        for (int i = 0; i < NSLV; i++) beat(1, 0, 0, 1, ad(i, 3 + i), 32'h1100_0000 + 32'(i), 4'hF);
        for (int i = 0; i < NSLV; i++) beat(1, 0, 0, 0, ad(i, 3 + i), '0, 4'hF);
        tag = "R9";
        beat(1, 0, 0, 0, ad(4, 40), '0, 4'hF);
        idle(2);

        tag = "R11";  // partial byte enables
        beat(1, 0, 0, 1, ad(2, 5), 32'hDEAD_BEEF, 4'b0101);
        beat(1, 0, 0, 0, ad(2, 5), '0, 4'b0011);
        idle(2);

        tag = "R3";  // numbers without a slave
        beat(1, 0, 0, 1, ad(7, 1), 32'h5555_5555, 4'hF);
        beat(1, 0, 0, 0, ad(15, 1), '0, 4'hF);
        beat(1, 0, 0, 0, ad(5, 1), '0, 4'hF);
        idle(2);

        tag = "R4";  // group write with m_cs also high, then read every slave
        beat(1, 1, 0, 1, ad(3, 10), 32'hCAFE_0010, 4'hF);
        for (int i = 0; i < NSLV; i++) beat(1, 0, 0, 0, ad(i, 10), '0, 4'hF);
        tag = "R5";
        beat(0, 1, 0, 0, ad(0, 10), '0, 4'hF);
        idle(2);

        tag = "R6";  // back-to-back posted writes
        for (int k = 0; k < 6; k++) beat(1, 0, 0, 1, ad(k % NSLV, 20 + k), 32'h6000_0000 + 32'(k), 4'hF);
        idle(3);

        tag = "R7";  // fill the queue while the slave waits
        s_wait = 1'b1;
        for (int k = 0; k < WB_DEPTH; k++) beat(1, 0, 0, 1, ad(1, 30 + k), 32'h7000_0000 + 32'(k), 4'hF);
        m_cs = 1; m_write = 1; m_addr = ad(1, 33); m_wdata = 32'h7000_0003; m_be = 4'hF;
        tag = "R13";
        for (int k = 0; k < 3; k++) step(took);
        s_wait = 1'b0;
        tag = "R7";
        beat(1, 0, 0, 1, ad(1, 33), 32'h7000_0003, 4'hF);
        idle(4);

        tag = "R8";  // read held behind queued writes
        s_wait = 1'b1;
        beat(1, 0, 0, 1, ad(0, 50), 32'h8000_0001, 4'hF);
        beat(1, 0, 0, 1, ad(0, 51), 32'h8000_0002, 4'hF);
        m_cs = 1; m_write = 0; m_addr = ad(0, 50);
        for (int k = 0; k < 2; k++) step(took);
        s_wait = 1'b0;
        beat(1, 0, 0, 0, ad(0, 50), '0, 4'hF);
        idle(2);

        tag = "R10";  // bursts: write, read, group write
        for (int k = 0; k < BEATS; k++) beat(1, 0, (k == 0), 1, ad(1, 16), 32'hB000_0000 + 32'(k), 4'hF);
        for (int k = 0; k < BEATS; k++) beat(1, 0, (k == 0), 0, ad(1, 16), '0, 4'hF);
        for (int k = 0; k < BEATS; k++) beat(0, 1, (k == 0), 1, ad(0, 56), 32'hBB00_0000 + 32'(k), 4'b1100);
        beat(1, 0, 0, 0, ad(3, 60), '0, 4'hF);
        idle(4);

        tag = "R12";  // straight-through mode
        pass_mode = 1'b1;
        beat(1, 0, 0, 1, ad(2, 12), 32'hC000_0012, 4'hF);
        beat(1, 0, 0, 0, ad(2, 12), '0, 4'hF);
        beat(0, 1, 0, 1, ad(0, 13), 32'hC000_0013, 4'b0110);
        beat(1, 0, 0, 0, ad(9, 13), '0, 4'hF);
        idle(1);
        pass_mode = 1'b0;
        idle(2);

        tag = "R6";  // final memory image matches ordered writes
        for (int i = 0; i < NSLV; i++)
            for (int j = 0; j < 64; j++)
                chk(smem[i][j] === rmem[i][j], "slave memory", 64'(smem[i][j]), 64'(rmem[i][j]));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule